// File: doc/BRIEF.md
# Best-Offset Prefetch Learner

This block learns which fixed line distance best predicts the next useful cache line, and once a good distance has been found it issues prefetch addresses along it. On every triggering access it tests one candidate distance from a built-in list. The test is a lookup into an external table of recently completed requests, and a hit raises that candidate's score. The pointer then moves on to the next candidate. When a learning phase closes, the strongest candidate either becomes the active offset with prefetching switched on, or prefetching is switched off.

The candidates are the numbers with no prime factor other than 2, 3 and 5, in increasing order. They can optionally be interleaved with their negations. The phase length is bounded both by a score ceiling and by a count of full passes over the list. While prefetching is on, each access produces a burst of addresses, one per cycle, on a valid/ready stream. The next access is held off until the burst has drained. Setting negative offsets together with an odd list length is rejected at elaboration.

Top module: `bo_learner`

## Requirements
- R1: List entry k (0-based index) holds the k-th 2/3/5-smooth number (1,2,3,4,5,6,8,9,...) when negatives are off. With negatives on, entry 2m holds the m-th such number and entry 2m+1 holds its negation (1,-1,2,-2,3,-3,...).
- R2: Each accepted access raises `lk_req` for exactly one candidate. The tag is bits [LINE_LOG2 +: TAG_W] of (access address − offset·2^LINE_LOG2), computed modulo 2^ADDR_W. After the response the pointer advances, and wrapping from the last entry to entry 0 adds one to the round count.
- R3: `lk_hit` with `lk_ack` raises the tested candidate's score by one, saturating at SCORE_MAX. A score strictly above the phase best replaces both the phase best score and the phase best offset, so a later equal score does not displace an earlier one.
- R4: A phase closes on the access where the phase best score reaches SCORE_MAX or the round count reaches ROUND_MAX. This clears every score, the round count, the phase best score and the phase best offset.
- R5: At phase close, a phase best score strictly above BAD_SCORE loads the phase best offset into `best_off` and sets `pf_en`. Otherwise `pf_en` is cleared and `best_off` is kept, so a phase best of exactly BAD_SCORE disables issue.
- R6: After reset `best_off` is 1, `pf_en` is 0, `acc_ready` is 1 and `pf_valid` is 0.
- R7: The enable value that results from an access's own lookup decides whether that access issues. When it issues, it emits addresses access + i·best_off·2^LINE_LOG2 for i = 1..DEGREE, in increasing i, one per accepted beat.
- R8: `acc_ready` is 0 from the accept until the last prefetch beat is taken, and a stalled beat keeps `pf_addr` stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid | input | 1 | Triggering access present |
| acc_ready | output | 1 | Block can take an access |
| acc_addr | input | ADDR_W | Byte address of the access |
| lk_req | output | 1 | Lookup request to the recent-request table |
| lk_tag | output | TAG_W | Tag to look up |
| lk_ack | input | 1 | Lookup response present |
| lk_hit | input | 1 | Tag was found, qualified by `lk_ack` |
| best_off | output | OFF_W | Active offset in lines, two's complement |
| pf_en | output | 1 | Prefetch issue enabled |
| pf_valid | output | 1 | Prefetch address present |
| pf_ready | input | 1 | Downstream takes the prefetch address |
| pf_addr | output | ADDR_W | Prefetch byte address |

## Verification
The hardest situation to reach is a phase close with a chosen outcome. The bench has to steer a specific candidate's score across several full passes of the pointer while every other candidate misses. It does this with a table responder that hits only when the tag equals the tag of the current access moved back by one chosen distance. That makes the access index of every hit, and so the access on which the phase closes, predictable. Both close conditions are reached this way, as is the exact-threshold case. Negative candidates are found by their list position.

// File: rtl/bo_pkg.sv
package bo_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_LOOK = 1'b1
  } bo_state_e;

  // n-th (1-based) positive integer whose only prime factors are 2, 3, 5
  function automatic int smooth_nth(input int n);
    int cnt;
    int res;
    int x;
    cnt = 0;
    res = 1;
    for (int c = 1; c <= 1024; c++) begin
      x = c;
      for (int j = 0; j < 10; j++) begin
        if (x % 2 == 0) x = x / 2;
        if (x % 3 == 0) x = x / 3;
        if (x % 5 == 0) x = x / 5;
      end
      if (x == 1) begin
        cnt = cnt + 1;
        if (cnt == n) res = c;
      end
    end
    return res;
  endfunction

  // candidate value at list position idx
  function automatic int offset_at(input int idx, input int neg);
    int v;
    if (neg != 0) begin
      v = smooth_nth(idx / 2 + 1);
      if (idx % 2 == 1) v = -v;
    end else begin
      v = smooth_nth(idx + 1);
    end
    return v;
  endfunction

endpackage

// File: rtl/bo_offset_table.sv
module bo_offset_table #(
  parameter int N_OFF  = 16,
  parameter int NEG_EN = 0,
  parameter int OFF_W  = 16,
  parameter int IDX_W  = 4
) (
  input  logic [IDX_W-1:0]        idx,
  output logic signed [OFF_W-1:0] off
);
  import bo_pkg::*;

  logic signed [OFF_W-1:0] tbl [N_OFF];

  if ((NEG_EN != 0) && (N_OFF % 2 != 0)) begin : g_cfg_bad
    $error("negated candidates need an even list length");
  end

  for (genvar g = 0; g < N_OFF; g++) begin : g_entry
    assign tbl[g] = OFF_W'(offset_at(g, NEG_EN));
  end

  assign off = tbl[idx];

endmodule

// File: rtl/bo_score_bank.sv
module bo_score_bank #(
  parameter int N_OFF     = 16,
  parameter int SCORE_MAX = 31,
  parameter int IDX_W     = 4,
  parameter int SCORE_W   = 5
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               clr,
  input  logic               inc,
  input  logic [IDX_W-1:0]   idx,
  output logic [SCORE_W-1:0] score_nxt
);

  logic [SCORE_W-1:0] score_q [N_OFF];
  logic [SCORE_W-1:0] cur;

  always_comb begin
    cur       = score_q[idx];
    score_nxt = (cur >= SCORE_W'(SCORE_MAX)) ? cur : cur + SCORE_W'(1);
  end

  for (genvar g = 0; g < N_OFF; g++) begin : g_ctr
    logic               we;
    logic [SCORE_W-1:0] d;

    always_comb begin
      we = clr | (inc && (idx == IDX_W'(g)));
      d  = clr ? '0 : score_nxt;
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        score_q[g] <= '0;
      end else if (we) begin
        score_q[g] <= d;
      end
    end

    AST_SCORE_SAT: assert property (@(posedge clk) disable iff (!rst_ni)
      score_q[g] <= SCORE_W'(SCORE_MAX)); // R3
  end

endmodule

// File: rtl/bo_pf_gen.sv
module bo_pf_gen #(
  parameter int ADDR_W    = 32,
  parameter int LINE_LOG2 = 6,
  parameter int OFF_W     = 16,
  parameter int DEGREE    = 1,
  parameter int CNT_W     = 1
) (
  input  logic                    clk,
  input  logic                    rst_ni,
  input  logic                    start,
  input  logic [ADDR_W-1:0]       base,
  input  logic signed [OFF_W-1:0] best,
  input  logic                    pf_ready,
  output logic                    pf_valid,
  output logic [ADDR_W-1:0]       pf_addr
);

  logic                    valid_q, valid_d;
  logic [CNT_W-1:0]        cnt_q, cnt_d;
  logic [ADDR_W-1:0]       base_q;
  logic signed [OFF_W-1:0] best_q;
  logic [ADDR_W-1:0]       step;
  logic                    load;

  always_comb begin
    valid_d = valid_q;
    cnt_d   = cnt_q;
    load    = 1'b0;
    if (start) begin
      valid_d = 1'b1;
      cnt_d   = CNT_W'(1);
      load    = 1'b1;
    end else if (valid_q && pf_ready) begin
      if (cnt_q == CNT_W'(DEGREE)) begin
        valid_d = 1'b0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      valid_q <= valid_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      best_q <= '0;
    end else if (load) begin
      base_q <= base;
      best_q <= best;
    end
  end

  always_comb begin
    step    = ADDR_W'(best_q) * ADDR_W'(cnt_q);
    pf_addr = base_q + (step << LINE_LOG2);
  end
  assign pf_valid = valid_q;

  AST_PF_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr)); // R8
  AST_BEAT_RANGE: assert property (@(posedge clk) disable iff (!rst_ni)
    pf_valid |-> (cnt_q >= CNT_W'(1)) && (cnt_q <= CNT_W'(DEGREE))); // R7

endmodule

// File: rtl/bo_learner.sv
module bo_learner #(
  parameter int ADDR_W    = 32,
  parameter int LINE_LOG2 = 6,
  parameter int TAG_W     = 12,
  parameter int OFF_W     = 16,
  parameter int N_OFF     = 16,
  parameter int NEG_EN    = 0,
  parameter int SCORE_MAX = 31,
  parameter int ROUND_MAX = 100,
  parameter int BAD_SCORE = 1,
  parameter int DEGREE    = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_valid,
  output logic                    acc_ready,
  input  logic [ADDR_W-1:0]       acc_addr,
  output logic                    lk_req,
  output logic [TAG_W-1:0]        lk_tag,
  input  logic                    lk_ack,
  input  logic                    lk_hit,
  output logic signed [OFF_W-1:0] best_off,
  output logic                    pf_en,
  output logic                    pf_valid,
  input  logic                    pf_ready,
  output logic [ADDR_W-1:0]       pf_addr
);
  import bo_pkg::*;

  localparam int IDX_W   = (N_OFF > 1) ? $clog2(N_OFF) : 1;
  localparam int SCORE_W = $clog2(SCORE_MAX + 1);
  localparam int RND_W   = $clog2(ROUND_MAX + 1);
  localparam int CNT_W   = $clog2(DEGREE + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  bo_state_e               state_q, state_d;
  logic [ADDR_W-1:0]       base_q;
  logic [IDX_W-1:0]        ptr_q, ptr_d;
  logic [RND_W-1:0]        round_q, round_d;
  logic [SCORE_W-1:0]      bscore_q, bscore_d;
  logic signed [OFF_W-1:0] poff_q, poff_d;
  logic signed [OFF_W-1:0] best_q, best_d;
  logic                    en_q, en_d;

  logic                    acc_fire;
  logic signed [OFF_W-1:0] cur_off;
  logic [SCORE_W-1:0]      score_nxt;
  logic                    sc_inc, sc_clr, pf_start, wrap;
  logic [SCORE_W-1:0]      ph_score;
  logic signed [OFF_W-1:0] ph_off;
  logic [RND_W-1:0]        ph_round;
  logic [ADDR_W-1:0]       look_addr;

  bo_offset_table #(
    .N_OFF (N_OFF), .NEG_EN(NEG_EN), .OFF_W(OFF_W), .IDX_W(IDX_W)
  ) u_tbl (
    .idx(ptr_q), .off(cur_off)
  );

  bo_score_bank #(
    .N_OFF(N_OFF), .SCORE_MAX(SCORE_MAX), .IDX_W(IDX_W), .SCORE_W(SCORE_W)
  ) u_scores (
    .clk(clk), .rst_ni(rst_ni), .clr(sc_clr), .inc(sc_inc),
    .idx(ptr_q), .score_nxt(score_nxt)
  );

  bo_pf_gen #(
    .ADDR_W(ADDR_W), .LINE_LOG2(LINE_LOG2), .OFF_W(OFF_W),
    .DEGREE(DEGREE), .CNT_W(CNT_W)
  ) u_issue (
    .clk(clk), .rst_ni(rst_ni), .start(pf_start), .base(base_q),
    .best(best_d), .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_addr(pf_addr)
  );

  assign acc_ready = (state_q == ST_IDLE) && !pf_valid;
  assign acc_fire  = acc_valid && acc_ready;
  assign lk_req    = (state_q == ST_LOOK);

  // lookup tag taken in the address domain, so negative results just wrap
  always_comb begin
    look_addr = base_q - (ADDR_W'(cur_off) << LINE_LOG2);
    lk_tag    = look_addr[LINE_LOG2 +: TAG_W];
  end

  always_comb begin
    state_d  = state_q;
    ptr_d    = ptr_q;
    round_d  = round_q;
    bscore_d = bscore_q;
    poff_d   = poff_q;
    best_d   = best_q;
    en_d     = en_q;
    sc_inc   = 1'b0;
    sc_clr   = 1'b0;
    pf_start = 1'b0;
    wrap     = (ptr_q == IDX_W'(N_OFF - 1));
    ph_score = bscore_q;
    ph_off   = poff_q;
    ph_round = round_q + RND_W'(wrap);
    case (state_q)
      ST_IDLE: begin
        if (acc_fire) state_d = ST_LOOK;
      end
      ST_LOOK: begin
        if (lk_ack) begin
          state_d = ST_IDLE;
          if (lk_hit) begin
            sc_inc = 1'b1;
            if (score_nxt > bscore_q) begin
              ph_score = score_nxt;
              ph_off   = cur_off;
            end
          end
          ptr_d    = wrap ? '0 : ptr_q + IDX_W'(1);
          round_d  = ph_round;
          bscore_d = ph_score;
          poff_d   = ph_off;
          if ((ph_score >= SCORE_W'(SCORE_MAX)) ||
              (ph_round >= RND_W'(ROUND_MAX))) begin
            round_d  = '0;
            bscore_d = '0;
            poff_d   = '0;
            sc_clr   = 1'b1;
            if (ph_score > SCORE_W'(BAD_SCORE)) begin
              best_d = ph_off;
              en_d   = 1'b1;
            end else begin
              en_d   = 1'b0;
            end
          end
          pf_start = en_d;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ptr_q    <= '0;
      round_q  <= '0;
      bscore_q <= '0;
      poff_q   <= '0;
      best_q   <= OFF_W'(1);
      en_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      ptr_q    <= ptr_d;
      round_q  <= round_d;
      bscore_q <= bscore_d;
      poff_q   <= poff_d;
      best_q   <= best_d;
      en_q     <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) base_q <= '0;
    else if (acc_fire) base_q <= acc_addr;
  end

  assign best_off = best_q;
  assign pf_en    = en_q;

  AST_ONE_LOOKUP: assert property (@(posedge clk) disable iff (!rst_ni)
    lk_req && lk_ack |=> !lk_req); // R2
  AST_ROUND_BOUND: assert property (@(posedge clk) disable iff (!rst_ni)
    round_q < RND_W'(ROUND_MAX)); // R4
  AST_OFF_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(best_off) |-> pf_en); // R5
  AST_ACC_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_ni)
    acc_valid && acc_ready |=> !acc_ready); // R8

endmodule

// File: tb/tb_bo_learner.sv
`timescale 1ns/1ps
module tb_bo_learner;

  localparam int ADDR_W = 32;
  localparam int LL     = 6;
  localparam int TAG_W  = 12;
  localparam int OFF_W  = 16;
  localparam int DEG    = 2;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    acc_valid;
  logic                    acc_ready;
  logic [ADDR_W-1:0]       acc_addr;
  logic                    lk_req;
  logic [TAG_W-1:0]        lk_tag;
  logic                    lk_ack;
  logic                    lk_hit;
  logic signed [OFF_W-1:0] best_off;
  logic                    pf_en;
  logic                    pf_valid;
  logic                    pf_ready;
  logic [ADDR_W-1:0]       pf_addr;

  int checks = 0;
  int errors = 0;
  int acc_n  = 0;
  int good_k = 0;
  bit hit_en = 1'b0;
  logic [ADDR_W-1:0] cur_addr = '0;
  logic [ADDR_W-1:0] exp_look;

  always #2 clk = ~clk;

  bo_learner #(
    .ADDR_W(ADDR_W), .LINE_LOG2(LL), .TAG_W(TAG_W), .OFF_W(OFF_W),
    .N_OFF(8), .NEG_EN(1), .SCORE_MAX(3), .ROUND_MAX(4),
    .BAD_SCORE(1), .DEGREE(DEG)
  ) dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_addr(acc_addr), .lk_req(lk_req), .lk_tag(lk_tag), .lk_ack(lk_ack),
    .lk_hit(lk_hit), .best_off(best_off), .pf_en(pf_en),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
  );

  // recent-request table model: holds exactly the line good_k behind the access
  assign exp_look = cur_addr - ADDR_W'(good_k * 64);
  assign lk_ack   = lk_req;
  assign lk_hit   = hit_en && (lk_tag == exp_look[LL +: TAG_W]);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one access; exp_en/exp_off are the values after its own lookup
  task automatic access(input bit hit, input bit exp_en, input int exp_off,
                        input bit stall, input string req);
    logic [ADDR_W-1:0] a;
    a = 32'h0010_0000 + ADDR_W'(acc_n) * 32'h1000;
    acc_n++;
    @(negedge clk);
    chk(acc_ready == 1'b1, "R8", "ready before access", acc_ready, 1);
    hit_en = hit; cur_addr = a; acc_valid = 1'b1; acc_addr = a;
    @(negedge clk);
    acc_valid = 1'b0;
    chk(lk_req == 1'b1, "R2", "lookup raised", lk_req, 1);
    @(negedge clk);
    hit_en = 1'b0;
    chk(pf_en == exp_en, req, "pf_en", pf_en, exp_en);
    chk(int'(best_off) == exp_off, req, "best_off", int'(best_off), exp_off);
    if (exp_en) begin
      if (stall) begin
        pf_ready = 1'b0;
        @(negedge clk);
        chk(pf_valid && pf_addr == a + ADDR_W'(exp_off * 64), "R8",
            "stalled beat held", pf_addr, a + ADDR_W'(exp_off * 64));
        chk(acc_ready == 1'b0, "R8", "no accept during burst", acc_ready, 0);
        pf_ready = 1'b1;
      end
      for (int i = 1; i <= DEG; i++) begin
        chk(pf_valid == 1'b1, "R7", "beat valid", pf_valid, 1);
        chk(pf_addr == a + ADDR_W'(i * exp_off * 64), "R7", "beat address",
            pf_addr, a + ADDR_W'(i * exp_off * 64));
        @(negedge clk);
      end
    end
    chk(pf_valid == 1'b0, "R7", "burst length", pf_valid, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; acc_valid = 1'b0; acc_addr = '0; pf_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(best_off == 16'sd1, "R6", "best_off in reset", best_off, 1);
    chk(pf_en == 1'b0, "R6", "pf_en in reset", pf_en, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(acc_ready == 1'b1, "R6", "acc_ready after reset", acc_ready, 1);
    chk(pf_valid == 1'b0, "R6", "pf_valid after reset", pf_valid, 0);
  endtask

  // +2 is entry 2: hits on accesses 3, 11, 19; score ceiling closes at 19
  task automatic t_learn_pos;
    good_k = 2;
    for (int k = 1; k <= 19; k++)
      access(1'b1, k >= 19, (k >= 19) ? 2 : 1, 1'b0, (k == 19) ? "R5" : "R3");
  endtask

  // -3 is entry 5 (R1 ordering); pointer starts at entry 3
  task automatic t_learn_neg;
    good_k = -3;
    for (int k = 1; k <= 19; k++)
      access(1'b1, 1'b1, (k >= 19) ? -3 : 2, k == 1, "R1");
  endtask

  // no hits: round limit closes the phase on access 26 and issue stops
  task automatic t_round_limit;
    for (int k = 1; k <= 26; k++)
      access(1'b0, k < 26, -3, 1'b0, "R4");
  endtask

  // a single hit equals the bad threshold: issue stays off
  task automatic t_threshold;
    good_k = 1;
    for (int k = 1; k <= 32; k++)
      access(k == 1, 1'b0, -3, 1'b0, "R5");
  endtask

  // +4 is entry 6: hits on 7, 15, 23 accumulate across rounds
  task automatic t_accumulate;
    good_k = 4;
    for (int k = 1; k <= 23; k++)
      access(1'b1, k >= 23, (k >= 23) ? 4 : -3, 1'b0, "R3");
  endtask

  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_learn_pos();
    t_learn_neg();
    t_round_limit();
    t_threshold();
    t_accumulate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule